// File: doc/BRIEF.md
# Dual-Clock Three-Line Video Buffer

This block holds up to three lines of packed video words. Lines are written from a pixel clock and read from an unrelated display clock. The read side always shows two vertically adjacent lines at the same horizontal address: the oldest unreleased line on the upper port and the line below it on the lower port. A vertical interpolator can therefore blend a line with its successor. The interpolator may read the same pair for as many output lines as its scale factor needs. It then requests an advance, which frees the oldest line for the writer to reuse.

Each stored word is 32 bits wide and packs two pixels, for example luma, chroma, luma, chroma. A line holds up to `LINE_WORDS` words, which is 360 by default and gives 720 pixels. Software has no control over the block. A line opens on a word flagged as start-of-line. It closes when its last word slot is filled or when the next start-of-line word arrives. Line counts cross between the two clocks as Gray code through two-flop synchronizers. The writer waits while all three slots hold lines that are still needed.

The write controller has two states. In `W_IDLE` no line is open. Taking a start-of-line word moves it to `W_FILL`. In `W_FILL` a line is being filled. A new start-of-line word stays in `W_FILL` and commits the old line. Filling the last word slot commits the line and returns to `W_IDLE`. The read controller also has two states. `R_WAIT` means fewer than two committed lines exist, and it moves to `R_PAIR` once two are present. On an advance, `R_PAIR` stays in `R_PAIR` if at least three lines were committed and falls back to `R_WAIT` otherwise.

Top module: `tri_line_cdc_buffer`

## Requirements
- R1: After reset of both domains `rd_ready` is 0, `wr_ready` is 1 while no word is offered, and the buffer holds no lines.
- R2: An accepted word with `wr_valid` and `wr_sol` both 1 is stored at word 0 of a new line. Each further accepted word goes to the next word address.
- R3: A line is committed when word `LINE_WORDS-1` is written or when the next start-of-line word is accepted. Valid words without `wr_sol` that arrive while no line is open are discarded.
- R4: `wr_ready` is 0 when a start-of-line word is offered and no free slot remains. That case is three committed unreleased lines with no line open, or two committed lines plus an open line.
- R5: `rd_ready` is 1 only while at least two committed lines are unreleased. A committed line becomes visible to the read side within a few `rclk` cycles.
- R6: `rd_top` carries the word at `rd_addr` of the oldest unreleased line, and `rd_bot` carries the same word of the next line. Both appear one `rclk` cycle after the address.
- R7: Without `rd_advance` the same pair stays readable indefinitely. An `rd_advance` while `rd_ready` is 1 releases the oldest line, so the old lower line becomes the upper line.
- R8: An `rd_advance` while `rd_ready` is 0 has no effect on which lines are presented.
- R9: A released slot is reused by the writer. Once a release has crossed into the write domain, `wr_ready` returns to 1 for a start-of-line word, and lines keep rotating through the three slots with correct contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Video write clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_valid | input | 1 | Write word offered |
| wr_sol | input | 1 | Offered word is the first of a line |
| wr_data | input | DATA_W | Packed two-pixel word |
| wr_ready | output | 1 | Offered word is taken on this edge |
| rclk | input | 1 | Display read clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_advance | input | 1 | Release the oldest line |
| rd_addr | input | ADDR_W | Word address read on both ports |
| rd_ready | output | 1 | A line pair is available |
| rd_top | output | DATA_W | Word of the upper (older) line |
| rd_bot | output | DATA_W | Word of the lower (newer) line |

## Verification
Wrong slot bookkeeping is visible at the data ports one `rclk` cycle after the next address. The upper or lower port then returns a word tagged with the wrong line number, or a stale word from a slot that was overwritten. A wrong occupancy count shows up at the handshakes. It can raise `wr_ready` when three lines are pinned, or leave `rd_ready` high with one line. It can also let an advance issued while not ready shift the pair, and the next pair read after the following line write exposes that. Counter crossing faults appear as `rd_ready` or `wr_ready` failing to change within a few cycles of a commit or release.

// File: rtl/lb_pkg.sv
package lb_pkg;

    localparam int CNT_W = 3;

    typedef enum logic {W_IDLE, W_FILL} wr_state_t;
    typedef enum logic {R_WAIT, R_PAIR} rd_state_t;

    function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic [1:0] slot_inc(input logic [1:0] s);
        return (s == 2'd2) ? 2'd0 : s + 2'd1;
    endfunction

endpackage

// File: rtl/lb_line_ram.sv
module lb_line_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 360,
    parameter int AW     = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/lb_gray_sync.sv
module lb_gray_sync
    import lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);

    logic [CNT_W-1:0] stage1_q;
    logic [CNT_W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    assign bin_out = gray2bin(stage2_q);

endmodule

// File: rtl/lb_wr_ctrl.sv
module lb_wr_ctrl
    import lb_pkg::*;
#(
    parameter int LINE_WORDS = 360,
    parameter int AW         = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_sol,
    output logic             wr_ready,
    input  logic [CNT_W-1:0] rcnt_sync,
    output logic [CNT_W-1:0] wcnt_bin,
    output logic [CNT_W-1:0] wcnt_gray,
    output logic [2:0]       ram_we,
    output logic [AW-1:0]    ram_addr
);

    localparam logic [AW-1:0] LAST = AW'(LINE_WORDS - 1);

    wr_state_t        state_q, state_d;
    logic [AW-1:0]    waddr_q, waddr_d;
    logic [1:0]       wslot_q, wslot_d;
    logic [CNT_W-1:0] wcnt_q, wcnt_d;
    logic [CNT_W-1:0] wgray_q;
    logic [CNT_W-1:0] occ;
    logic             acc;
    logic [1:0]       tgt_slot;

    assign occ = wcnt_q - rcnt_sync;

    // outputs
    always_comb begin
        wr_ready = 1'b1;
        unique case (state_q)
            W_IDLE: wr_ready = (occ < CNT_W'(3));
            W_FILL: wr_ready = !wr_sol || (occ < CNT_W'(2));
        endcase
        acc      = wr_valid && wr_ready;
        tgt_slot = (state_q == W_FILL && wr_sol) ? slot_inc(wslot_q) : wslot_q;
        ram_addr = wr_sol ? '0 : waddr_q;
        ram_we   = (acc && (wr_sol || state_q == W_FILL)) ? (3'b001 << tgt_slot) : 3'b000;
    end

    // next state
    always_comb begin
        state_d = state_q;
        waddr_d = waddr_q;
        wslot_d = wslot_q;
        wcnt_d  = wcnt_q;
        unique case (state_q)
            W_IDLE: begin
                if (acc && wr_sol) begin
                    state_d = W_FILL;
                    waddr_d = AW'(1);
                end
            end
            W_FILL: begin
                if (acc) begin
                    if (wr_sol) begin
                        wcnt_d  = wcnt_q + CNT_W'(1);
                        wslot_d = slot_inc(wslot_q);
                        waddr_d = AW'(1);
                    end else if (waddr_q == LAST) begin
                        wcnt_d  = wcnt_q + CNT_W'(1);
                        wslot_d = slot_inc(wslot_q);
                        waddr_d = '0;
                        state_d = W_IDLE;
                    end else begin
                        waddr_d = waddr_q + AW'(1);
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            waddr_q <= '0;
            wslot_q <= '0;
            wcnt_q  <= '0;
            wgray_q <= '0;
        end else begin
            state_q <= state_d;
            waddr_q <= waddr_d;
            wslot_q <= wslot_d;
            wcnt_q  <= wcnt_d;
            wgray_q <= bin2gray(wcnt_d);
        end
    end

    assign wcnt_bin  = wcnt_q;
    assign wcnt_gray = wgray_q;

endmodule

// File: rtl/lb_rd_ctrl.sv
module lb_rd_ctrl
    import lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_advance,
    input  logic [CNT_W-1:0] wcnt_sync,
    output logic             rd_ready,
    output logic [CNT_W-1:0] rcnt_bin,
    output logic [CNT_W-1:0] rcnt_gray,
    output logic [1:0]       top_slot,
    output logic [1:0]       bot_slot
);

    rd_state_t        state_q, state_d;
    logic [CNT_W-1:0] rcnt_q, rcnt_d;
    logic [CNT_W-1:0] rgray_q;
    logic [1:0]       rslot_q, rslot_d;
    logic [CNT_W-1:0] occ;

    assign occ = wcnt_sync - rcnt_q;

    // next state
    always_comb begin
        state_d = state_q;
        rcnt_d  = rcnt_q;
        rslot_d = rslot_q;
        unique case (state_q)
            R_WAIT: begin
                if (occ >= CNT_W'(2)) begin
                    state_d = R_PAIR;
                end
            end
            R_PAIR: begin
                if (rd_advance) begin
                    rcnt_d  = rcnt_q + CNT_W'(1);
                    rslot_d = slot_inc(rslot_q);
                    state_d = (occ >= CNT_W'(3)) ? R_PAIR : R_WAIT;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_WAIT;
            rcnt_q  <= '0;
            rgray_q <= '0;
            rslot_q <= '0;
        end else begin
            state_q <= state_d;
            rcnt_q  <= rcnt_d;
            rgray_q <= bin2gray(rcnt_d);
            rslot_q <= rslot_d;
        end
    end

    // outputs
    always_comb begin
        rd_ready  = (state_q == R_PAIR);
        rcnt_bin  = rcnt_q;
        rcnt_gray = rgray_q;
        top_slot  = rslot_q;
        bot_slot  = slot_inc(rslot_q);
    end

endmodule

// File: rtl/tri_line_cdc_buffer.sv
module tri_line_cdc_buffer
    import lb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 360,
    localparam int ADDR_W    = $clog2(LINE_WORDS)
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_valid,
    input  logic              wr_sol,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_advance,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_top,
    output logic [DATA_W-1:0] rd_bot
);

    localparam int SLOTS = 3;

    logic [CNT_W-1:0]  wcnt_w, wgray_w, rsync_w;
    logic [CNT_W-1:0]  rcnt_r, rgray_r, wsync_r;
    logic [SLOTS-1:0]  ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [1:0]        top_slot, bot_slot;
    logic [1:0]        top_sel_q, bot_sel_q;
    logic [DATA_W-1:0] slot_q [SLOTS];

    lb_wr_ctrl #(.LINE_WORDS(LINE_WORDS), .AW(ADDR_W)) u_wr (
        .clk       (wclk),
        .rst_n     (wrst_n),
        .wr_valid  (wr_valid),
        .wr_sol    (wr_sol),
        .wr_ready  (wr_ready),
        .rcnt_sync (rsync_w),
        .wcnt_bin  (wcnt_w),
        .wcnt_gray (wgray_w),
        .ram_we    (ram_we),
        .ram_addr  (ram_waddr)
    );

    lb_gray_sync u_r2w (
        .clk     (wclk),
        .rst_n   (wrst_n),
        .gray_in (rgray_r),
        .bin_out (rsync_w)
    );

    lb_gray_sync u_w2r (
        .clk     (rclk),
        .rst_n   (rrst_n),
        .gray_in (wgray_w),
        .bin_out (wsync_r)
    );

    lb_rd_ctrl u_rd (
        .clk        (rclk),
        .rst_n      (rrst_n),
        .rd_advance (rd_advance),
        .wcnt_sync  (wsync_r),
        .rd_ready   (rd_ready),
        .rcnt_bin   (rcnt_r),
        .rcnt_gray  (rgray_r),
        .top_slot   (top_slot),
        .bot_slot   (bot_slot)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_line
        lb_line_ram #(.DATA_W(DATA_W), .DEPTH(LINE_WORDS), .AW(ADDR_W)) u_ram (
            .wclk  (wclk),
            .we    (ram_we[s]),
            .waddr (ram_waddr),
            .wdata (wr_data),
            .rclk  (rclk),
            .raddr (rd_addr),
            .rdata (slot_q[s])
        );
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            top_sel_q <= 2'd0;
            bot_sel_q <= 2'd1;
        end else begin
            top_sel_q <= top_slot;
            bot_sel_q <= bot_slot;
        end
    end

    assign rd_top = slot_q[top_sel_q];
    assign rd_bot = slot_q[bot_sel_q];

endmodule

// File: rtl/lb_buffer_chk.sv
module lb_buffer_chk
    import lb_pkg::*;
(
    input logic             wclk,
    input logic             wrst_n,
    input logic             rclk,
    input logic             rrst_n,
    input logic             rd_ready,
    input logic             rd_advance,
    input logic [CNT_W-1:0] wcnt_w,
    input logic [CNT_W-1:0] rsync_w,
    input logic [CNT_W-1:0] rcnt_r,
    input logic [CNT_W-1:0] wsync_r
);

    // R4
    no_overwrite_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        CNT_W'(wcnt_w - rsync_w) <= CNT_W'(3));

    // R5
    pair_ready_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_ready |-> (CNT_W'(wsync_r - rcnt_r) >= CNT_W'(2)));

    // R7
    hold_pair_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        !rd_advance |=> $stable(rcnt_r));

    // R7
    advance_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_ready && rd_advance) |=> (rcnt_r == CNT_W'($past(rcnt_r) + CNT_W'(1))));

    // R8
    adv_ignored_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        !rd_ready |=> $stable(rcnt_r));

endmodule

bind tri_line_cdc_buffer lb_buffer_chk u_chk (
    .wclk       (wclk),
    .wrst_n     (wrst_n),
    .rclk       (rclk),
    .rrst_n     (rrst_n),
    .rd_ready   (rd_ready),
    .rd_advance (rd_advance),
    .wcnt_w     (wcnt_w),
    .rsync_w    (rsync_w),
    .rcnt_r     (rcnt_r),
    .wsync_r    (wsync_r)
);

// File: tb/tb_tri_line_cdc_buffer.sv
module tb_tri_line_cdc_buffer;

    localparam int DW = 32;
    localparam int LW = 8;
    localparam int AW = 3;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          wrst_n = 1'b0;
    logic          rrst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_sol = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_advance = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_ready;
    logic          rd_ready;
    logic [DW-1:0] rd_top;
    logic [DW-1:0] rd_bot;

    tri_line_cdc_buffer #(.DATA_W(DW), .LINE_WORDS(LW)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_sol(wr_sol),
        .wr_data(wr_data), .wr_ready(wr_ready), .rclk(rclk), .rrst_n(rrst_n),
        .rd_advance(rd_advance), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_top(rd_top), .rd_bot(rd_bot)
    );

    always #4 wclk = ~wclk;   // 125 MHz
    always #5 rclk = ~rclk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int ql[$];
    int llen [0:31];

    typedef struct {
        logic [DW-1:0] t;
        logic [DW-1:0] b;
        string         rq;
    } exp_t;
    exp_t sb[$];
    logic issue = 1'b0;
    logic issue_q = 1'b0;

    function automatic logic [DW-1:0] word(input int id, input int a);
        return {8'hC5, 8'(id), 16'(a)};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    task automatic put_word(input logic sol, input logic [DW-1:0] d);
        @(negedge wclk);
        wr_valid = 1'b1;
        wr_sol   = sol;
        wr_data  = d;
        #1;
        while (!wr_ready) begin
            @(negedge wclk);
            #1;
        end
        @(posedge wclk);
        #1;
        wr_valid = 1'b0;
        wr_sol   = 1'b0;
    endtask

    task automatic line_body(input int id, input int from, input int n);
        for (int a = from; a < n; a++) put_word(1'b0, word(id, a));
    endtask

    task automatic send_line(input int id, input int n);
        put_word(1'b1, word(id, 0));
        line_body(id, 1, n);
    endtask

    task automatic commit(input int id, input int n);
        ql.push_back(id);
        llen[id] = n;
    endtask

    task automatic probe_sol(input int id, input logic expv, input string rq);
        @(negedge wclk);
        wr_valid = 1'b1;
        wr_sol   = 1'b1;
        wr_data  = word(id, 0);
        #1;
        chk(wr_ready == expv, rq, DW'(wr_ready), DW'(expv));
        @(posedge wclk);
        #1;
        wr_valid = 1'b0;
        wr_sol   = 1'b0;
    endtask

    task automatic wait_rd(input string rq);
        int k = 0;
        while (!rd_ready && k < 40) begin
            @(negedge rclk);
            k++;
        end
        chk(rd_ready == 1'b1, rq, DW'(rd_ready), 32'd1);
    endtask

    task automatic read_pair(input int n, input string rq);
        for (int a = 0; a < n; a++) begin
            @(negedge rclk);
            rd_addr = AW'(a);
            issue   = 1'b1;
            sb.push_back('{word(ql[0], a), word(ql[1], a), rq});
        end
        @(negedge rclk);
        issue = 1'b0;
        repeat (2) @(negedge rclk);
    endtask

    task automatic advance();
        logic was;
        @(negedge rclk);
        was = rd_ready;
        rd_advance = 1'b1;
        @(negedge rclk);
        rd_advance = 1'b0;
        if (was) void'(ql.pop_front());
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // scoreboard monitor
    always @(posedge rclk) issue_q <= issue;

    always @(negedge rclk) begin
        if (issue_q && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(rd_top == e.t, e.rq, rd_top, e.t);
            chk(rd_bot == e.b, e.rq, rd_bot, e.b);
        end
    end

    initial begin
        repeat (60000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge wclk);
        // R1: reset state
        chk(rd_ready == 1'b0, "R1", DW'(rd_ready), 32'd0);
        chk(wr_ready == 1'b1, "R1", DW'(wr_ready), 32'd1);
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        repeat (2) @(negedge wclk);

        // R2, R3: full line commits on its last word
        send_line(0, LW);
        commit(0, LW);
        repeat (12) @(negedge rclk);
        chk(rd_ready == 1'b0, "R5", DW'(rd_ready), 32'd0);

        // R3: short line closed by the next start-of-line word
        send_line(1, 5);
        send_line(2, 4);
        commit(1, 5);
        wait_rd("R5");
        read_pair(5, "R6");
        read_pair(5, "R7");

        // R4: open line plus two committed lines
        probe_sol(3, 1'b0, "R4");

        advance();
        repeat (6) @(negedge rclk);
        chk(rd_ready == 1'b0, "R7", DW'(rd_ready), 32'd0);

        // R9: freed slot lets a new line start
        repeat (10) @(negedge wclk);
        probe_sol(3, 1'b1, "R9");
        commit(2, 4);
        line_body(3, 1, LW);
        commit(3, LW);

        // R3: stray words with no line open are discarded
        for (int i = 0; i < 3; i++) begin
            @(negedge wclk);
            wr_valid = 1'b1;
            wr_sol   = 1'b0;
            wr_data  = 32'hDEAD_0000 + DW'(i);
            @(posedge wclk);
            #1;
            wr_valid = 1'b0;
        end

        // R4: three committed lines, no line open
        probe_sol(4, 1'b0, "R4");

        wait_rd("R5");
        read_pair(min2(llen[ql[0]], llen[ql[1]]), "R6");
        advance();
        chk(rd_ready == 1'b1, "R7", DW'(rd_ready), 32'd1);
        read_pair(min2(llen[ql[0]], llen[ql[1]]), "R7");
        advance();
        repeat (3) @(negedge rclk);
        chk(rd_ready == 1'b0, "R7", DW'(rd_ready), 32'd0);

        // R8: advance while not ready does nothing
        advance();
        repeat (3) @(negedge rclk);
        chk(rd_ready == 1'b0, "R8", DW'(rd_ready), 32'd0);
        send_line(4, LW);
        commit(4, LW);
        wait_rd("R8");
        read_pair(LW, "R8");

        // R9: rotate through the slots several times
        for (int id = 5; id < 11; id++) begin
            advance();
            send_line(id, LW);
            commit(id, LW);
            wait_rd("R9");
            read_pair(LW, "R9");
        end

        // R1: reset mid-operation empties the buffer
        wrst_n = 1'b0;
        rrst_n = 1'b0;
        repeat (3) @(negedge rclk);
        chk(rd_ready == 1'b0, "R1", DW'(rd_ready), 32'd0);
        chk(wr_ready == 1'b1, "R1", DW'(wr_ready), 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule